// File: doc/BRIEF.md
# Warm Reset Handshake Sequencer

This block stands between a warm-reset trigger and the warm-reset line that goes to downstream logic. When the trigger rises, the block can first run a request/acknowledge exchange with up to two peer controllers. One peer is a scan controller and the other is a fabric-configuration controller. Each exchange gives that peer the chance to bring its output clocks to rest before reset arrives. An exchange is left out when its enable bit is clear. It is also left out when the peer already reports that it is in warm reset at the moment of the trigger.

A control register is visible to software. It holds the two enable bits and a software request to the fabric controller to idle its clock, which lets software park that clock without a reset. It also holds a request that puts the external memory into self-refresh. Both requests have read-only status bits that show the synchronized acknowledges. Every hardware exchange has a cycle-count timeout, so a silent peer cannot block reset. When a timeout expires, a sticky flag is set. The warm-reset output is held for a fixed minimum number of cycles and is then released on a clock edge.

The trigger, both acknowledges, both in-reset indications and the memory acknowledge can arrive from other clock domains. Each passes through a two-flop synchronizer before the sequencer uses it.

Top module: `warm_rst_seq`

## Requirements
- R1: After reset, the register reads 0, all requests and `warm_rst_o` are low, and `hs_timeout_o` is 0.
- R2: Register bits 12 (scan enable), 9 (software idle request), 8 (fabric enable) and 5 (self-refresh request) can be written and read back. Writes to every other bit are ignored, so writing 0xFFFFFDFF reads back 0x00001120 while both acknowledges are low.
- R3: Bit 9 drives `fab_req_o`. Bit 10 reads the synchronized `fab_ack_i`.
- R4: Bit 5 drives `mem_sr_req_o` from the cycle after the write. Bit 6 reads the synchronized `mem_sr_ack_i`.
- R5: A rising edge on the synchronized trigger starts a sequence. The scan exchange runs first, then the fabric exchange, then warm reset, and no two of these phases overlap.
- R6: An enabled exchange holds its request until the synchronized acknowledge is seen. If the peer raises its acknowledge D cycles after the request rises, the request stays high for D+2 cycles.
- R7: An exchange whose enable bit is 0 is skipped, and its request never rises.
- R8: An exchange is skipped, even when enabled, if that peer's in-reset input is high when the trigger is recognized.
- R9: An exchange ends without an acknowledge after `tmo_limit_i` cycles of request. The sequence then goes on, and `hs_timeout_o` becomes 1 and stays 1 until reset.
- R10: `warm_rst_o` is high for exactly HOLD_CYCLES cycles with `scan_req_o` low. The block then goes back to idle, and a trigger that stays high does not start a second sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Write strobe for the control register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Control register read value |
| tmo_limit_i | input | TO_W | Handshake timeout in cycles |
| warm_trig_i | input | 1 | Warm-reset trigger (asynchronous) |
| scan_in_rst_i | input | 1 | Scan controller already in warm reset |
| fab_in_rst_i | input | 1 | Fabric controller already in warm reset |
| scan_ack_i | input | 1 | Scan controller clock-quiescent acknowledge |
| fab_ack_i | input | 1 | Fabric controller clock-idle acknowledge |
| mem_sr_ack_i | input | 1 | Memory self-refresh acknowledge |
| scan_req_o | output | 1 | Request to scan controller |
| fab_req_o | output | 1 | Request to fabric controller (hardware or software) |
| mem_sr_req_o | output | 1 | Self-refresh request to memory controller |
| warm_rst_o | output | 1 | Warm-reset output |
| hs_timeout_o | output | 1 | Sticky handshake-timeout flag |

## Verification
Trigger sequences are run with both exchanges enabled, with one exchange disabled, with none enabled and with the fabric peer already in reset. Comparing the observed order of request and reset pulses separates correct skip logic from a wrong enable decode or a wrong in-reset decode. Peer response delays of 1 to 3 cycles give request lengths of D+2, which shows whether the acknowledge path has the right synchronizer depth. A peer that never answers checks the timeout length and the sticky flag. The software idle request and the self-refresh request are exercised apart from any trigger, and register writes with all bits set check the read/write field mask.

// File: rtl/wrs_pkg.sv
package wrs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_FAB  = 2'd2,
        ST_HOLD = 2'd3
    } wrs_state_e;

    // control register bit positions (software-visible contract)
    localparam int B_SCAN_EN  = 12;
    localparam int B_FAB_ACK  = 10;
    localparam int B_IDLE_REQ = 9;
    localparam int B_FAB_EN   = 8;
    localparam int B_SR_ACK   = 6;
    localparam int B_SR_REQ   = 5;

    // synchronizer lane assignment
    localparam int N_SYNC     = 6;
    localparam int S_TRIG     = 0;
    localparam int S_SCAN_ACK = 1;
    localparam int S_FAB_ACK  = 2;
    localparam int S_SCAN_RST = 3;
    localparam int S_FAB_RST  = 4;
    localparam int S_MEM_ACK  = 5;

    typedef struct packed {
        logic scan_en;
        logic fab_en;
        logic idle_req;
        logic sr_req;
    } wrs_ctrl_t;

endpackage

// File: rtl/wrs_sync.sv
module wrs_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/wrs_ctrl_reg.sv
module wrs_ctrl_reg
    import wrs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    input  logic        fab_ack_s,
    input  logic        mem_ack_s,
    output logic [31:0] rdata,
    output wrs_ctrl_t   ctrl
);
    wrs_ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            ctrl_d.scan_en  = wdata[B_SCAN_EN];
            ctrl_d.fab_en   = wdata[B_FAB_EN];
            ctrl_d.idle_req = wdata[B_IDLE_REQ];
            ctrl_d.sr_req   = wdata[B_SR_REQ];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    always_comb begin
        rdata             = '0;
        rdata[B_SCAN_EN]  = ctrl_q.scan_en;
        rdata[B_FAB_ACK]  = fab_ack_s;
        rdata[B_IDLE_REQ] = ctrl_q.idle_req;
        rdata[B_FAB_EN]   = ctrl_q.fab_en;
        rdata[B_SR_ACK]   = mem_ack_s;
        rdata[B_SR_REQ]   = ctrl_q.sr_req;
    end

    assign ctrl = ctrl_q;
endmodule

// File: rtl/warm_rst_seq.sv
module warm_rst_seq
    import wrs_pkg::*;
#(
    parameter int TO_W        = 8,
    parameter int HOLD_CYCLES = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr_en,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    input  logic [TO_W-1:0] tmo_limit_i,
    input  logic            warm_trig_i,
    input  logic            scan_in_rst_i,
    input  logic            fab_in_rst_i,
    input  logic            scan_ack_i,
    input  logic            fab_ack_i,
    input  logic            mem_sr_ack_i,
    output logic            scan_req_o,
    output logic            fab_req_o,
    output logic            mem_sr_req_o,
    output logic            warm_rst_o,
    output logic            hs_timeout_o
);
    localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);
    localparam int CNT_W  = ((TO_W > HOLD_W) ? TO_W : HOLD_W) + 1;

    typedef struct packed {
        wrs_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             fab_need;
        logic             trig_prev;
        logic             tmo;
    } seq_t;

    logic [N_SYNC-1:0] raw, syn;
    wrs_ctrl_t         ctrl;
    seq_t              seq_d, seq_q;
    logic [CNT_W-1:0]  cnt_inc;
    logic              hs_last, hold_last, trig_rise;
    logic              scan_need, fab_need;

    always_comb begin
        raw             = '0;
        raw[S_TRIG]     = warm_trig_i;
        raw[S_SCAN_ACK] = scan_ack_i;
        raw[S_FAB_ACK]  = fab_ack_i;
        raw[S_SCAN_RST] = scan_in_rst_i;
        raw[S_FAB_RST]  = fab_in_rst_i;
        raw[S_MEM_ACK]  = mem_sr_ack_i;
    end

    wrs_sync #(.W(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw),
        .q     (syn)
    );

    wrs_ctrl_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .wdata     (reg_wdata),
        .fab_ack_s (syn[S_FAB_ACK]),
        .mem_ack_s (syn[S_MEM_ACK]),
        .rdata     (reg_rdata),
        .ctrl      (ctrl)
    );

    assign cnt_inc   = seq_q.cnt + 1'b1;
    assign hs_last   = cnt_inc >= CNT_W'(tmo_limit_i);
    assign hold_last = seq_q.cnt == CNT_W'(HOLD_CYCLES - 1);
    assign trig_rise = syn[S_TRIG] && !seq_q.trig_prev;
    assign scan_need = ctrl.scan_en && !syn[S_SCAN_RST];
    assign fab_need  = ctrl.fab_en  && !syn[S_FAB_RST];

    always_comb begin
        seq_d           = seq_q;
        seq_d.trig_prev = syn[S_TRIG];
        unique case (seq_q.st)
            ST_IDLE: begin
                seq_d.cnt = '0;
                if (trig_rise) begin
                    seq_d.fab_need = fab_need;
                    if (scan_need)     seq_d.st = ST_SCAN;
                    else if (fab_need) seq_d.st = ST_FAB;
                    else               seq_d.st = ST_HOLD;
                end
            end
            ST_SCAN: begin
                seq_d.cnt = cnt_inc;
                if (syn[S_SCAN_ACK] || hs_last) begin
                    if (!syn[S_SCAN_ACK]) seq_d.tmo = 1'b1;
                    seq_d.cnt = '0;
                    seq_d.st  = seq_q.fab_need ? ST_FAB : ST_HOLD;
                end
            end
            ST_FAB: begin
                seq_d.cnt = cnt_inc;
                if (syn[S_FAB_ACK] || hs_last) begin
                    if (!syn[S_FAB_ACK]) seq_d.tmo = 1'b1;
                    seq_d.cnt = '0;
                    seq_d.st  = ST_HOLD;
                end
            end
            ST_HOLD: begin
                seq_d.cnt = cnt_inc;
                if (hold_last) begin
                    seq_d.cnt = '0;
                    seq_d.st  = ST_IDLE;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: ST_IDLE, default: '0};
        else        seq_q <= seq_d;
    end

    assign scan_req_o   = seq_q.st == ST_SCAN;
    assign fab_req_o    = (seq_q.st == ST_FAB) || ctrl.idle_req;
    assign warm_rst_o   = seq_q.st == ST_HOLD;
    assign mem_sr_req_o = ctrl.sr_req;
    assign hs_timeout_o = seq_q.tmo;
endmodule

// File: rtl/wrs_chk.sv
module wrs_chk #(
    parameter int HOLD_CYCLES = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr_en,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        scan_req_o,
    input logic        mem_sr_req_o,
    input logic        warm_rst_o,
    input logic        hs_timeout_o
);
    AST_RW_SCAN_EN: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> reg_rdata[12] == $past(reg_wdata[12])); // R2

    AST_RW_FAB_EN: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> reg_rdata[8] == $past(reg_wdata[8])); // R2

    AST_SR_REQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_wdata[5]) |=> mem_sr_req_o); // R4

    AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        hs_timeout_o |=> hs_timeout_o); // R9

    AST_RST_NO_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst_o |-> !scan_req_o); // R10

    AST_RST_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(warm_rst_o) && HOLD_CYCLES > 1) |=> warm_rst_o); // R10
endmodule

bind warm_rst_seq wrs_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_wrs_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr_en    (reg_wr_en),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .scan_req_o   (scan_req_o),
    .mem_sr_req_o (mem_sr_req_o),
    .warm_rst_o   (warm_rst_o),
    .hs_timeout_o (hs_timeout_o)
);

// File: tb/warm_rst_seq_bench.sv
`timescale 1ns/1ps
module warm_rst_seq_bench;
    localparam int TO_W = 8;
    localparam int HOLD = 4;

    localparam int K_SCAN = 0;
    localparam int K_FAB  = 1;
    localparam int K_RST  = 2;

    typedef struct {
        int    kind;
        int    len;
        string tag;
    } item_t;

    logic            clk = 0;
    logic            rst_n = 0;
    logic            reg_wr_en = 0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [TO_W-1:0] tmo_limit = 8'd10;
    logic            warm_trig = 0, scan_in_rst = 0, fab_in_rst = 0;
    logic            scan_ack = 0, fab_ack = 0, mem_ack = 0;
    logic            scan_req, fab_req, mem_sr_req, warm_rst, hs_tmo;

    int    n_chk = 0, n_bad = 0;
    int    scan_d = 1, fab_d = 1, scan_cnt = 0, fab_cnt = 0;
    item_t exp_q[$];
    bit    finished = 0;

    always #10 clk = ~clk;

    warm_rst_seq #(.TO_W(TO_W), .HOLD_CYCLES(HOLD), .SYNC_STAGES(2)) u_warm_rst_seq (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tmo_limit_i(tmo_limit), .warm_trig_i(warm_trig),
        .scan_in_rst_i(scan_in_rst), .fab_in_rst_i(fab_in_rst), .scan_ack_i(scan_ack),
        .fab_ack_i(fab_ack), .mem_sr_ack_i(mem_ack), .scan_req_o(scan_req),
        .fab_req_o(fab_req), .mem_sr_req_o(mem_sr_req), .warm_rst_o(warm_rst),
        .hs_timeout_o(hs_tmo)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_pulse(input int kind, input int len, input string tag);
        item_t it;
        it.kind = kind; it.len = len; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic wr(input logic [31:0] v);
        reg_wr_en = 1; reg_wdata = v;
        @(negedge clk);
        reg_wr_en = 0;
    endtask

    task automatic run_seq();
        warm_trig = 1;
        do @(negedge clk); while (exp_q.size() != 0);
        repeat (10) @(negedge clk);   // trigger held high: no re-run (R10)
        warm_trig = 0;
        repeat (6) @(negedge clk);
    endtask

    // peer models: ack D samples after request seen high
    always @(negedge clk) begin
        if (scan_req) begin
            scan_cnt = scan_cnt + 1;
            if (scan_cnt >= scan_d) scan_ack = 1;
        end else begin
            scan_cnt = 0; scan_ack = 0;
        end
        if (fab_req) begin
            fab_cnt = fab_cnt + 1;
            if (fab_cnt >= fab_d) fab_ack = 1;
        end else begin
            fab_cnt = 0; fab_ack = 0;
        end
    end

    // monitor: measure pulse lengths, compare with scoreboard
    int   run_len [3] = '{0, 0, 0};
    logic prev_lv [3] = '{0, 0, 0};
    always @(negedge clk) begin
        logic cur [3];
        cur[K_SCAN] = scan_req; cur[K_FAB] = fab_req; cur[K_RST] = warm_rst;
        if (rst_n) begin
            for (int k = 0; k < 3; k++) begin
                if (cur[k] === 1'b1) begin
                    run_len[k]++;
                end else if (prev_lv[k] === 1'b1) begin
                    n_chk++;
                    if (exp_q.size() == 0) begin
                        n_bad++;
                        $display("FAIL R10 unexpected pulse kind=%0d len=%0d expected none", k, run_len[k]);
                    end else begin
                        item_t it;
                        it = exp_q.pop_front();
                        if (it.kind != k || it.len != run_len[k]) begin
                            n_bad++;
                            $display("FAIL %s actual kind=%0d len=%0d expected kind=%0d len=%0d",
                                     it.tag, k, run_len[k], it.kind, it.len);
                        end
                    end
                    run_len[k] = 0;
                end
            end
        end
        for (int k = 0; k < 3; k++) prev_lv[k] = cur[k];
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 rdata", reg_rdata, 32'h0);
        check("R1 outputs", {28'h0, scan_req, fab_req, warm_rst, hs_tmo}, 32'h0);

        // R2 field mask, R4 self-refresh
        wr(32'hFFFF_FDFF);
        check("R2 mask", reg_rdata, 32'h0000_1120);
        check("R4 sr req", {31'h0, mem_sr_req}, 32'h1);
        mem_ack = 1;
        repeat (3) @(negedge clk);
        check("R4 sr ack bit6", {31'h0, reg_rdata[6]}, 32'h1);
        mem_ack = 0;
        wr(32'h0);
        repeat (3) @(negedge clk);
        check("R2 clear", reg_rdata, 32'h0);

        // R3 software idle request
        fab_d = 1;
        expect_pulse(K_FAB, 6, "R3");
        wr(32'h0000_0200);
        repeat (5) @(negedge clk);
        check("R3 fab ack bit10", {31'h0, reg_rdata[10]}, 32'h1);
        wr(32'h0);
        repeat (6) @(negedge clk);
        check("R3 ack cleared", {31'h0, reg_rdata[10]}, 32'h0);

        // R5/R6 both enabled, ordered
        scan_d = 2; fab_d = 3; tmo_limit = 8'd10;
        wr(32'h0000_1100);
        expect_pulse(K_SCAN, 4, "R6 scan");
        expect_pulse(K_FAB, 5, "R6 fab");
        expect_pulse(K_RST, HOLD, "R5 order");
        run_seq();

        // R7 scan disabled
        fab_d = 1;
        wr(32'h0000_0100);
        expect_pulse(K_FAB, 3, "R7");
        expect_pulse(K_RST, HOLD, "R7");
        run_seq();

        // R8 fabric peer already in reset
        scan_d = 1;
        wr(32'h0000_1100);
        fab_in_rst = 1;
        repeat (4) @(negedge clk);
        expect_pulse(K_SCAN, 3, "R8");
        expect_pulse(K_RST, HOLD, "R8");
        run_seq();
        fab_in_rst = 0;

        // R7 nothing enabled
        wr(32'h0);
        expect_pulse(K_RST, HOLD, "R7 none");
        run_seq();
        check("R9 no timeout yet", {31'h0, hs_tmo}, 32'h0);

        // R9 scan peer never answers
        scan_d = 1000; fab_d = 1; tmo_limit = 8'd6;
        wr(32'h0000_1100);
        expect_pulse(K_SCAN, 6, "R9 scan timeout");
        expect_pulse(K_FAB, 3, "R9 continues");
        expect_pulse(K_RST, HOLD, "R9 reset");
        run_seq();
        check("R9 sticky flag", {31'h0, hs_tmo}, 32'h1);
        repeat (5) @(negedge clk);
        check("R9 flag held", {31'h0, hs_tmo}, 32'h1);
        check("R10 idle after", {29'h0, scan_req, fab_req, warm_rst}, 32'h0);
        check("R10 queue drained", exp_q.size(), 32'h0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule